// File: doc/BRIEF.md
# Video Frame Lock Clock-Enable Controller

This block ties a free-running graphics display timing generator to an external interlaced video source. The graphics timing is programmed so that its frame ends a few lines before one input field does. The graphics side therefore always finishes first. When the graphics frame ends, the controller drops a clock enable, which freezes the graphics timing. The enable comes back once the input's vertical sync has arrived and a programmable number of system clocks has elapsed after it.

Two further functions sit on top of the per-frame lock. The first is a one-shot parity match. While it is enabled, the controller waits through one extra input field if the input's odd/even flag disagrees with the TV encoder's flag at the lock point. Once the two agree it reports itself aligned and does not repeat the match. The second is a stall guard. It releases the frozen graphics timing if no vertical sync arrives within a programmable number of cycles, and it records that event in a sticky flag.

Top module: `vid_frame_lock`

## Requirements
- R1: After reset, `gfx_clk_en` is 1, `lock_phase` is 0 (run), and both `lock_aligned` and `stall_flag` are 0.
- R2: With `lock_en` high and `lock_phase` = 0, a `gfx_eof` pulse drives `gfx_clk_en` to 0 and `lock_phase` to 1 (waiting for sync) from the next cycle.
- R3: While `lock_en` is low, `gfx_eof` has no effect and `gfx_clk_en` stays 1.
- R4: `vid_vsync` is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector. With `sync_delay` = 0, `gfx_clk_en` is back at 1 after the third rising clock edge, counted from the first edge that samples `vid_vsync` high.
- R5: With `sync_delay` = D > 0, `lock_phase` reads 2 (delay) for D cycles after the sync edge is detected, and the release comes D cycles later than for D = 0.
- R6: A `vid_vsync` held high gives only one release. A later frame end then waits for a fresh rising edge.
- R7: With `stall_en` high and `stall_limit` = L > 0, a wait with no sync edge keeps `gfx_clk_en` at 0 for exactly L cycles. At the end of that wait it returns to 1 and `stall_flag` sets. With `stall_en` low or L = 0 there is no timeout. The stall counter only advances in phases 1 and 3.
- R8: `stall_flag` stays set until a cycle with `stall_clr` high. If a new timeout occurs in the same cycle as the clear, the flag ends up set.
- R9: If a sync edge and a timeout expiry fall in the same cycle, the sync edge wins. The delay phase follows and `stall_flag` is not set.
- R10: Taking `lock_en` low in any phase gives phase 0 and `gfx_clk_en` = 1 on the next cycle.
- R11: With `fsync_en` high and `lock_aligned` low, a sync edge seen while the synchronized `vid_field` differs from `enc_field` enters phase 3 (field align). The controller keeps the clock stopped there until a sync edge arrives with matching flags, and then continues as in R4/R5.
- R12: `lock_aligned` sets on the first sync edge seen with matching flags while `fsync_en` is high. It stays set, and suppresses any further field align, until `fsync_en` goes low, which clears it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_en | input | 1 | Master enable for frame locking |
| fsync_en | input | 1 | Enables the one-shot odd/even match |
| stall_en | input | 1 | Enables the stall timeout |
| sync_delay | input | DLY_W | Extra system clocks after the sync edge |
| stall_limit | input | TMO_W | Stall timeout length in cycles (0 disables) |
| stall_clr | input | 1 | Clears `stall_flag` (write-one pulse) |
| vid_vsync | input | 1 | Video input vertical sync, asynchronous |
| vid_field | input | 1 | Video input odd/even flag, asynchronous |
| enc_field | input | 1 | TV encoder odd/even flag, system domain |
| gfx_eof | input | 1 | Graphics end-of-frame pulse |
| gfx_clk_en | output | 1 | Clock enable for graphics timing |
| lock_phase | output | 2 | 0 run, 1 wait sync, 2 delay, 3 field align |
| lock_aligned | output | 1 | Odd/even match achieved |
| stall_flag | output | 1 | Sticky timeout status |

## Verification
A sync edge and a stall expiry can land in the same cycle. The bench provokes this by driving `vid_vsync` exactly two cycles before the last waiting cycle that the stall limit allows, with a nonzero delay programmed. If the controller handled the two correctly, it must show the delay phase with the clock still stopped and the flag clear. If the timeout had won, it would already be running with the flag set. The flag's clear and set are also forced into one cycle, and the bench checks that the set wins.

// File: rtl/vfl_pkg.sv
package vfl_pkg;
   typedef enum logic [1:0] {
      PH_RUN   = 2'd0,
      PH_WAIT  = 2'd1,
      PH_DELAY = 2'd2,
      PH_ALIGN = 2'd3
   } vfl_phase_e;
endpackage

// File: rtl/vfl_sync.sv
module vfl_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vfl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[LAST];
endmodule

// File: rtl/vfl_delay.sv
module vfl_delay #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             done
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   generate
      if (DLY_W < 1) begin : g_bad_width
         $error("vfl_delay: DLY_W must be positive");
      end
   endgenerate

   logic [DLY_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= load_val;
      else if (remain != '0)   remain <= remain - ONE;
   end

   assign done = (remain == ONE);

   // R5: a fresh load longer than one cycle cannot finish at once
   p_load_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val > ONE) |=> !done);
endmodule

// File: rtl/vfl_stall.sv
module vfl_stall #(
   parameter int  TMO_W    = 24,
   parameter bit  SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             count_en,
   input  logic             enable,
   input  logic [TMO_W-1:0] limit,
   output logic             fire
);
   localparam logic [TMO_W-1:0] ONE = TMO_W'(1);
   localparam logic [TMO_W-1:0] TOP = '1;

   generate
      if (TMO_W < 2) begin : g_bad_width
         $error("vfl_stall: TMO_W must be at least 2");
      end
   endgenerate

   logic [TMO_W-1:0] cnt;
   logic             step;

   generate
      if (SATURATE) begin : g_sat
         assign step = count_en && (cnt != TOP);
      end else begin : g_wrap
         assign step = count_en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (step)   cnt <= cnt + ONE;
   end

   assign fire = enable && count_en && (limit != '0) && (cnt == limit - ONE);

   // R7: the counter is idle while the clock runs
   p_idle_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));
endmodule

// File: rtl/vid_frame_lock.sv
module vid_frame_lock
   import vfl_pkg::*;
#(
   parameter int DLY_W       = 16,
   parameter int TMO_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_en,
   input  logic             fsync_en,
   input  logic             stall_en,
   input  logic [DLY_W-1:0] sync_delay,
   input  logic [TMO_W-1:0] stall_limit,
   input  logic             stall_clr,
   input  logic             vid_vsync,
   input  logic             vid_field,
   input  logic             enc_field,
   input  logic             gfx_eof,
   output logic             gfx_clk_en,
   output logic [1:0]       lock_phase,
   output logic             lock_aligned,
   output logic             stall_flag
);
   localparam int SYNC_W = 2;

   generate
      if (DLY_W > 32 || TMO_W > 32) begin : g_bad_widths
         $error("vid_frame_lock: counter widths above 32 not supported");
      end
   endgenerate

   // ---- input synchronisation ----
   logic [SYNC_W-1:0] sync_q;
   logic              vs_s, fld_s, vs_prev, vs_rise;

   vfl_sync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({vid_field, vid_vsync}),
      .q     (sync_q)
   );

   assign vs_s  = sync_q[0];
   assign fld_s = sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vs_prev <= 1'b0;
      else        vs_prev <= vs_s;
   end

   assign vs_rise = vs_s && !vs_prev;

   // ---- state and helpers ----
   vfl_phase_e phase_q, phase_d;
   logic       dly_load, dly_done, stall_fire, stall_counting;
   logic       parity_ok, set_aligned, set_stall;

   assign parity_ok      = (fld_s == enc_field);
   assign stall_counting = (phase_q == PH_WAIT) || (phase_q == PH_ALIGN);

   vfl_delay #(.DLY_W(DLY_W)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .load_val (sync_delay),
      .done     (dly_done)
   );

   vfl_stall #(.TMO_W(TMO_W), .SATURATE(1'b1)) u_stall (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (phase_q == PH_RUN),
      .count_en (stall_counting),
      .enable   (stall_en),
      .limit    (stall_limit),
      .fire     (stall_fire)
   );

   always_comb begin
      phase_d     = phase_q;
      dly_load    = 1'b0;
      set_aligned = 1'b0;
      set_stall   = 1'b0;
      unique case (phase_q)
         PH_RUN: begin
            if (gfx_eof) phase_d = PH_WAIT;
         end
         PH_WAIT, PH_ALIGN: begin
            if (vs_rise) begin
               if (fsync_en && !lock_aligned && !parity_ok) begin
                  phase_d = PH_ALIGN;
               end else begin
                  set_aligned = fsync_en && parity_ok;
                  if (sync_delay == '0) begin
                     phase_d = PH_RUN;
                  end else begin
                     phase_d  = PH_DELAY;
                     dly_load = 1'b1;
                  end
               end
            end else if (stall_fire) begin
               phase_d   = PH_RUN;
               set_stall = 1'b1;
            end
         end
         PH_DELAY: begin
            if (dly_done) phase_d = PH_RUN;
         end
         default: phase_d = PH_RUN;
      endcase
      if (!lock_en) begin
         phase_d   = PH_RUN;
         dly_load  = 1'b0;
         set_stall = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_RUN;
         lock_aligned <= 1'b0;
         stall_flag   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (!fsync_en)        lock_aligned <= 1'b0;
         else if (set_aligned) lock_aligned <= 1'b1;
         if (set_stall)        stall_flag   <= 1'b1;
         else if (stall_clr)   stall_flag   <= 1'b0;
      end
   end

   assign gfx_clk_en = (phase_q == PH_RUN);
   assign lock_phase = phase_q;

   // ---- assertions ----
   p_eof_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_en && gfx_eof && gfx_clk_en) |=> !gfx_clk_en);

   p_eof_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_en) |=> gfx_clk_en);

   p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> !vs_rise);

   p_release_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gfx_clk_en) |->
         $past(vs_rise) || $past(dly_done) || $past(stall_fire) || $past(!lock_en));

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_flag && !stall_clr) |=> stall_flag);

   p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_flag) |-> ($past(stall_counting) && gfx_clk_en));

   p_sync_beats_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_rise && stall_fire && lock_en && !stall_flag && !stall_clr) |=> !stall_flag);

   p_disable_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_en |=> (lock_phase == 2'd0));

   p_aligned_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_aligned && fsync_en) |=> lock_aligned);

   p_align_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_ALIGN && phase_d == PH_ALIGN) |-> (!lock_aligned && fsync_en));
endmodule

// File: tb/vid_frame_lock_test.sv
`timescale 1ns/1ps
module vid_frame_lock_test;
   localparam int DLY_W = 16;
   localparam int TMO_W = 24;
   localparam int NV    = 6;
   // each row: programmed delay, expected edges from vsync drive to release
   localparam int TBL [NV][2] = '{'{0, 3}, '{1, 4}, '{2, 5}, '{3, 6}, '{7, 10}, '{40, 43}};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lock_en = 1'b1, fsync_en = 1'b0, stall_en = 1'b0, stall_clr = 1'b0;
   logic [DLY_W-1:0] sync_delay = '0;
   logic [TMO_W-1:0] stall_limit = '0;
   logic             vid_vsync = 1'b0, vid_field = 1'b0, enc_field = 1'b0, gfx_eof = 1'b0;
   logic             gfx_clk_en, lock_aligned, stall_flag;
   logic [1:0]       lock_phase;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   vid_frame_lock #(.DLY_W(DLY_W), .TMO_W(TMO_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .fsync_en(fsync_en),
      .stall_en(stall_en), .sync_delay(sync_delay), .stall_limit(stall_limit),
      .stall_clr(stall_clr), .vid_vsync(vid_vsync), .vid_field(vid_field),
      .enc_field(enc_field), .gfx_eof(gfx_eof), .gfx_clk_en(gfx_clk_en),
      .lock_phase(lock_phase), .lock_aligned(lock_aligned), .stall_flag(stall_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic lock_frame();
      gfx_eof = 1'b1;
      @(negedge clk);
      gfx_eof = 1'b0;
   endtask

   // call right after driving vid_vsync high at a negedge
   task automatic measure(output int n, output int ph3);
      n = 0;
      ph3 = -1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         n++;
         if (n == 3) ph3 = int'(lock_phase);
         if (gfx_clk_en) break;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n, ph, low;
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 clk_en", int'(gfx_clk_en), 1);
      chk("R1 phase", int'(lock_phase), 0);
      chk("R1 aligned", int'(lock_aligned), 0);
      chk("R1 stall", int'(stall_flag), 0);

      // R3 frame end ignored while disabled
      lock_en = 1'b0;
      lock_frame();
      chk("R3 clk_en", int'(gfx_clk_en), 1);
      tick(1);
      lock_en = 1'b1;
      tick(1);

      // R2 frame end stops the clock
      lock_frame();
      chk("R2 clk_en", int'(gfx_clk_en), 0);
      chk("R2 phase", int'(lock_phase), 1);
      tick(2);
      vid_vsync = 1'b1;
      measure(n, ph);
      chk("R4 first release", n, 3);
      vid_vsync = 1'b0;
      tick(3);

      // R4/R5 vector table of delays
      for (int v = 0; v < NV; v++) begin
         sync_delay = DLY_W'(TBL[v][0]);
         lock_frame();
         tick(2);
         vid_vsync = 1'b1;
         measure(n, ph);
         chk(TBL[v][0] == 0 ? "R4 latency" : "R5 latency", n, TBL[v][1]);
         chk("R5 phase at sync", ph, TBL[v][0] == 0 ? 0 : 2);
         vid_vsync = 1'b0;
         tick(3);
      end

      // R6 held vsync gives no second release
      sync_delay = '0;
      lock_frame();
      vid_vsync = 1'b1;
      measure(n, ph);
      chk("R6 release", n, 3);
      lock_frame();
      tick(40);
      chk("R6 held", int'(gfx_clk_en), 0);
      chk("R6 phase", int'(lock_phase), 1);
      vid_vsync = 1'b0;
      tick(3);
      vid_vsync = 1'b1;
      measure(n, ph);
      chk("R6 new edge", n, 3);
      vid_vsync = 1'b0;
      tick(3);

      // R7 timeout length and flag
      stall_en = 1'b1;
      stall_limit = TMO_W'(20);
      lock_frame();
      low = 1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (gfx_clk_en) break;
         low++;
      end
      chk("R7 stopped cycles", low, 20);
      chk("R7 flag", int'(stall_flag), 1);

      // R8 sticky, then clear
      tick(5);
      chk("R8 sticky", int'(stall_flag), 1);
      stall_clr = 1'b1;
      tick(1);
      stall_clr = 1'b0;
      chk("R8 cleared", int'(stall_flag), 0);

      // R8 set wins over clear in the same cycle
      stall_limit = TMO_W'(6);
      lock_frame();
      tick(5);
      stall_clr = 1'b1;
      tick(1);
      stall_clr = 1'b0;
      chk("R8 set wins", int'(stall_flag), 1);
      chk("R8 released", int'(gfx_clk_en), 1);
      stall_clr = 1'b1;
      tick(1);
      stall_clr = 1'b0;

      // R7 no timeout when disabled or limit zero
      stall_en = 1'b0;
      lock_frame();
      tick(30);
      chk("R7 disabled", int'(gfx_clk_en), 0);
      stall_en = 1'b1;
      stall_limit = '0;
      tick(30);
      chk("R7 zero limit", int'(gfx_clk_en), 0);
      chk("R7 no flag", int'(stall_flag), 0);
      vid_vsync = 1'b1;
      measure(n, ph);
      vid_vsync = 1'b0;
      tick(3);

      // R9 sync edge and expiry in the same cycle
      stall_limit = TMO_W'(20);
      sync_delay = DLY_W'(4);
      lock_frame();
      tick(17);
      vid_vsync = 1'b1;
      tick(3);
      chk("R9 phase", int'(lock_phase), 2);
      chk("R9 flag", int'(stall_flag), 0);
      chk("R9 clk_en", int'(gfx_clk_en), 0);
      tick(4);
      chk("R9 release", int'(gfx_clk_en), 1);
      vid_vsync = 1'b0;
      tick(3);

      // R10 master disable releases
      stall_en = 1'b0;
      lock_frame();
      tick(3);
      lock_en = 1'b0;
      tick(1);
      chk("R10 clk_en", int'(gfx_clk_en), 1);
      chk("R10 phase", int'(lock_phase), 0);
      lock_en = 1'b1;
      tick(2);

      // R11 field align on mismatch
      sync_delay = DLY_W'(2);
      fsync_en = 1'b1;
      vid_field = 1'b1;
      enc_field = 1'b0;
      tick(4);
      lock_frame();
      tick(2);
      vid_vsync = 1'b1;
      tick(3);
      chk("R11 phase", int'(lock_phase), 3);
      chk("R11 clk_en", int'(gfx_clk_en), 0);
      chk("R11 aligned", int'(lock_aligned), 0);
      vid_vsync = 1'b0;
      vid_field = 1'b0;
      tick(6);
      vid_vsync = 1'b1;
      measure(n, ph);
      chk("R11 release", n, 5);
      chk("R12 aligned", int'(lock_aligned), 1);
      vid_vsync = 1'b0;

      // R12 only once: later mismatch does not realign
      vid_field = 1'b1;
      tick(4);
      lock_frame();
      tick(2);
      vid_vsync = 1'b1;
      measure(n, ph);
      chk("R12 once", n, 5);
      vid_vsync = 1'b0;
      tick(3);

      // R12 clear and direct match
      fsync_en = 1'b0;
      tick(1);
      chk("R12 cleared", int'(lock_aligned), 0);
      fsync_en = 1'b1;
      vid_field = 1'b0;
      tick(4);
      lock_frame();
      tick(2);
      vid_vsync = 1'b1;
      measure(n, ph);
      chk("R12 match release", n, 5);
      chk("R12 match aligned", int'(lock_aligned), 1);
      vid_vsync = 1'b0;
      tick(3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule